// File: doc/BRIEF.md
# Switch Egress Port-Mask Resolver

This block decides, for every frame that enters a 12-port Ethernet switch, which ports the frame leaves on. Software fills a shared table of 12-bit port masks and a few configuration registers through a single write port. Each lookup request carries the ingress port, whether the MAC table hit, the destination index from that hit, a flood class and a 4-bit hash. The block reads three masks from the table and ANDs them: a destination mask, an aggregation mask and a source (ingress permission) mask. It returns the resulting egress mask and a separate flag that asks for a copy to the CPU.

Table entries 0 to 11 conventionally hold one port each. Entries 12 to 63 hold multi-port groups, and entry 59 is by convention the group that holds only the CPU port bit. Entries 64 to 79 are aggregation masks, picked by the hash. Entries 80 to 91 are source masks: bit j of entry 80+i allows port i to send to port j. The CPU port is special. When a MAC-table hit selects a destination mask that contains the CPU port bit, the frame is copied to the CPU even if the ingress permission mask would block it. A flooded frame gets no such bypass. It reaches the CPU only if the CPU bit survives the full three-way AND.

Requests and responses use valid/ready handshakes. The pipeline has two register stages, so a response appears two clock edges after its request is accepted. A stalled response holds the pipeline.

Top module: `pmr_resolver`

## Requirements
- R1: Synchronous reset clears every table entry, the CPU port register (to 0) and the three flood index registers (to 0), and drops rsp_valid. Until software writes the table, any lookup returns an all-zero mask with rsp_cpu_copy low.
- R2: A request accepted on a clock edge (req_valid and req_ready both high) gives rsp_valid high after the second following edge and not after the first. While rsp_valid is high and rsp_ready is low, rsp_mask and rsp_cpu_copy hold their values and req_ready is low.
- R3: On a MAC-table hit (req_hit=1), the destination mask is table entry req_dest_idx.
- R4: On a miss, the destination mask is the table entry named by a flood index register chosen by req_class: 0 selects the unicast register, 1 the multicast register, and 2 or 3 the broadcast register.
- R5: rsp_mask equals destination mask AND entry 64+req_hash AND entry 80+req_src_port, with the bit of req_src_port then cleared.
- R6: On a hit whose destination mask has the bit of the configured CPU port set, rsp_cpu_copy is 1 regardless of the source mask, and the CPU bit is cleared from rsp_mask.
- R7: On a miss, rsp_cpu_copy is 0, and the CPU bit appears in rsp_mask only if all three masks carry it.
- R8: A write with cfg_wr_en=1 stores cfg_wr_data at table entry cfg_wr_addr for addresses 0 to 91. Address 96 loads the CPU port from data bits 3:0, and addresses 97, 98 and 99 load the unicast, multicast and broadcast flood indices from data bits 6:0. Writes to any other address change nothing.
- R9: A lookup accepted on the same edge as a table write uses the table contents from before that write.
- R10: A destination or flood index of 92 or more reads as an all-zero mask. A source port of 12 or more uses an all-zero source mask. A CPU port value of 12 or more never produces a CPU copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the table and configuration registers |
| cfg_wr_addr | input | 7 | Write address: table entry or configuration register |
| cfg_wr_data | input | 12 | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_src_port | input | 4 | Ingress port of the frame |
| req_hit | input | 1 | MAC table hit |
| req_dest_idx | input | 7 | Destination table index from the MAC table hit |
| req_class | input | 2 | Flood class used on a miss: 0 unicast, 1 multicast, 2/3 broadcast |
| req_hash | input | 4 | Frame hash that selects the aggregation entry |
| rsp_valid | output | 1 | Resolved result valid |
| rsp_ready | input | 1 | Downstream accepts the result |
| rsp_mask | output | 12 | Egress port mask |
| rsp_cpu_copy | output | 1 | Copy the frame to the CPU |

## Verification
Each lookup's mask and CPU-copy flag are due after the second clock edge that follows acceptance. The bench samples on the falling edge after that second edge. On the falling edge after the first edge it confirms that rsp_valid is still low. Expected values are computed when the request is driven, from a bench copy of the table taken before any write on the same edge. This makes the old-contents rule for a simultaneous write fall out of the timing. In the stall scenario two requests sit in the pipeline with rsp_ready low. The held output is sampled over several cycles, and the second result is checked exactly one edge after rsp_ready rises.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int NPORT      = 12;
    localparam int PORT_W     = $clog2(NPORT);
    localparam int IDX_W      = 7;
    localparam int HASH_W     = 4;
    localparam int TBL_DEPTH  = 92;
    localparam int AGGR_BASE  = 64;
    localparam int SRC_BASE   = 80;
    localparam int ADDR_CPU   = 96;
    localparam int ADDR_FL_UC = 97;
    localparam int ADDR_FL_MC = 98;
    localparam int ADDR_FL_BC = 99;

    typedef logic [NPORT-1:0]  pmask_t;
    typedef logic [PORT_W-1:0] port_t;
    typedef logic [IDX_W-1:0]  tidx_t;

    typedef enum logic [1:0] {
        FCLS_UC  = 2'd0,
        FCLS_MC  = 2'd1,
        FCLS_BC  = 2'd2,
        FCLS_BC2 = 2'd3
    } fclass_t;

    typedef struct packed {
        port_t  src;
        logic   hit;
        port_t  cpu;
        pmask_t dst;
        pmask_t aggr;
        pmask_t srcm;
    } s1_t;

    typedef struct packed {
        port_t  src;
        logic   hit;
        port_t  cpu;
        pmask_t mask;
        logic   cpu_copy;
    } s2_t;

    function automatic pmask_t port_bit(input port_t p);
        if (int'(p) < NPORT) return pmask_t'(1) << p;
        return '0;
    endfunction

    function automatic tidx_t src_entry(input port_t p);
        if (int'(p) < NPORT) return tidx_t'(SRC_BASE + int'(p));
        return '1;
    endfunction

endpackage

// File: rtl/pmr_table.sv
module pmr_table
    import pmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  tidx_t  wr_addr,
    input  pmask_t wr_data,
    input  tidx_t  rd_dst_idx,
    input  tidx_t  rd_aggr_idx,
    input  tidx_t  rd_src_idx,
    output pmask_t dst_mask,
    output pmask_t aggr_mask,
    output pmask_t src_mask,
    output port_t  cfg_cpu,
    output tidx_t  cfg_fl_uc,
    output tidx_t  cfg_fl_mc,
    output tidx_t  cfg_fl_bc
);

    pmask_t ent [TBL_DEPTH];

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (wr_en && wr_addr == tidx_t'(g))
                ent[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_cpu   <= '0;
            cfg_fl_uc <= '0;
            cfg_fl_mc <= '0;
            cfg_fl_bc <= '0;
        end else if (wr_en) begin
            case (int'(wr_addr))
                ADDR_CPU:   cfg_cpu   <= wr_data[PORT_W-1:0];
                ADDR_FL_UC: cfg_fl_uc <= wr_data[IDX_W-1:0];
                ADDR_FL_MC: cfg_fl_mc <= wr_data[IDX_W-1:0];
                ADDR_FL_BC: cfg_fl_bc <= wr_data[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        dst_mask  = (int'(rd_dst_idx)  < TBL_DEPTH) ? ent[rd_dst_idx]  : '0;
        aggr_mask = (int'(rd_aggr_idx) < TBL_DEPTH) ? ent[rd_aggr_idx] : '0;
        src_mask  = (int'(rd_src_idx)  < TBL_DEPTH) ? ent[rd_src_idx]  : '0;
    end

endmodule

// File: rtl/pmr_pipe.sv
module pmr_pipe
    import pmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    output logic   req_ready,
    input  port_t  req_src_port,
    input  logic   req_hit,
    input  tidx_t  req_dest_idx,
    input  logic [1:0] req_class,
    input  logic [HASH_W-1:0] req_hash,
    output tidx_t  rd_dst_idx,
    output tidx_t  rd_aggr_idx,
    output tidx_t  rd_src_idx,
    input  pmask_t dst_mask,
    input  pmask_t aggr_mask,
    input  pmask_t src_mask,
    input  port_t  cfg_cpu,
    input  tidx_t  cfg_fl_uc,
    input  tidx_t  cfg_fl_mc,
    input  tidx_t  cfg_fl_bc,
    output logic   rsp_valid,
    input  logic   rsp_ready,
    output pmask_t rsp_mask,
    output logic   rsp_cpu_copy,
    output logic   s1_valid_o,
    output port_t  s2_src_o,
    output logic   s2_hit_o,
    output port_t  s2_cpu_o
);

    logic advance;
    logic s1_valid;
    s1_t  s1_q;
    s2_t  s2_d, s2_q;

    assign advance   = !rsp_valid || rsp_ready;
    assign req_ready = advance;

    always_comb begin
        if (req_hit) begin
            rd_dst_idx = req_dest_idx;
        end else begin
            case (fclass_t'(req_class))
                FCLS_UC: rd_dst_idx = cfg_fl_uc;
                FCLS_MC: rd_dst_idx = cfg_fl_mc;
                default: rd_dst_idx = cfg_fl_bc;
            endcase
        end
        rd_aggr_idx = tidx_t'(AGGR_BASE + int'(req_hash));
        rd_src_idx  = src_entry(req_src_port);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_q     <= '0;
        end else if (advance) begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_q.src  <= req_src_port;
                s1_q.hit  <= req_hit;
                s1_q.cpu  <= cfg_cpu;
                s1_q.dst  <= dst_mask;
                s1_q.aggr <= aggr_mask;
                s1_q.srcm <= src_mask;
            end
        end
    end

    always_comb begin
        pmask_t cpu_b;
        cpu_b         = port_bit(s1_q.cpu);
        s2_d.src      = s1_q.src;
        s2_d.hit      = s1_q.hit;
        s2_d.cpu      = s1_q.cpu;
        s2_d.cpu_copy = s1_q.hit && ((s1_q.dst & cpu_b) != '0);
        s2_d.mask     = s1_q.dst & s1_q.aggr & s1_q.srcm & ~port_bit(s1_q.src);
        if (s2_d.cpu_copy)
            s2_d.mask = s2_d.mask & ~cpu_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            s2_q      <= '0;
        end else if (advance) begin
            rsp_valid <= s1_valid;
            if (s1_valid)
                s2_q <= s2_d;
        end
    end

    assign rsp_mask     = s2_q.mask;
    assign rsp_cpu_copy = s2_q.cpu_copy;
    assign s1_valid_o   = s1_valid;
    assign s2_src_o     = s2_q.src;
    assign s2_hit_o     = s2_q.hit;
    assign s2_cpu_o     = s2_q.cpu;

endmodule

// File: rtl/pmr_resolver.sv
module pmr_resolver
    import pmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [6:0]  cfg_wr_addr,
    input  logic [11:0] cfg_wr_data,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [3:0]  req_src_port,
    input  logic        req_hit,
    input  logic [6:0]  req_dest_idx,
    input  logic [1:0]  req_class,
    input  logic [3:0]  req_hash,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [11:0] rsp_mask,
    output logic        rsp_cpu_copy
);

    tidx_t  rd_dst_idx, rd_aggr_idx, rd_src_idx;
    pmask_t dst_mask, aggr_mask, src_mask;
    port_t  cfg_cpu;
    tidx_t  cfg_fl_uc, cfg_fl_mc, cfg_fl_bc;
    logic   s1_valid;
    port_t  s2_src;
    logic   s2_hit;
    port_t  s2_cpu;

    pmr_table u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .rd_dst_idx (rd_dst_idx),
        .rd_aggr_idx(rd_aggr_idx),
        .rd_src_idx (rd_src_idx),
        .dst_mask   (dst_mask),
        .aggr_mask  (aggr_mask),
        .src_mask   (src_mask),
        .cfg_cpu    (cfg_cpu),
        .cfg_fl_uc  (cfg_fl_uc),
        .cfg_fl_mc  (cfg_fl_mc),
        .cfg_fl_bc  (cfg_fl_bc)
    );

    pmr_pipe u_pipe (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_src_port(req_src_port),
        .req_hit     (req_hit),
        .req_dest_idx(req_dest_idx),
        .req_class   (req_class),
        .req_hash    (req_hash),
        .rd_dst_idx  (rd_dst_idx),
        .rd_aggr_idx (rd_aggr_idx),
        .rd_src_idx  (rd_src_idx),
        .dst_mask    (dst_mask),
        .aggr_mask   (aggr_mask),
        .src_mask    (src_mask),
        .cfg_cpu     (cfg_cpu),
        .cfg_fl_uc   (cfg_fl_uc),
        .cfg_fl_mc   (cfg_fl_mc),
        .cfg_fl_bc   (cfg_fl_bc),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_mask    (rsp_mask),
        .rsp_cpu_copy(rsp_cpu_copy),
        .s1_valid_o  (s1_valid),
        .s2_src_o    (s2_src),
        .s2_hit_o    (s2_hit),
        .s2_cpu_o    (s2_cpu)
    );

endmodule

// File: rtl/pmr_resolver_chk.sv
module pmr_resolver_chk
    import pmr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [11:0] rsp_mask,
    input logic        rsp_cpu_copy,
    input logic        s1_valid,
    input logic [3:0]  s2_src,
    input logic        s2_hit,
    input logic [3:0]  s2_cpu
);

    // R1
    rst_clears_rsp_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

    // R2
    accept_fills_stage1_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> s1_valid);

    // R2
    stall_holds_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask) && $stable(rsp_cpu_copy)));

    // R5
    no_self_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && int'(s2_src) < NPORT) |-> !(((rsp_mask >> s2_src) & 12'd1) != 12'd0));

    // R7
    cpu_copy_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cpu_copy) |-> s2_hit);

    // R6
    cpu_copy_not_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cpu_copy) |-> (int'(s2_cpu) < NPORT &&
            (((rsp_mask >> s2_cpu) & 12'd1) == 12'd0)));

endmodule

bind pmr_resolver pmr_resolver_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_mask    (rsp_mask),
    .rsp_cpu_copy(rsp_cpu_copy),
    .s1_valid    (s1_valid),
    .s2_src      (s2_src),
    .s2_hit      (s2_hit),
    .s2_cpu      (s2_cpu)
);

// File: tb/tb_pmr_resolver.sv
module tb_pmr_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [6:0]  cfg_wr_addr = '0;
    logic [11:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_src_port = '0;
    logic        req_hit = 1'b0;
    logic [6:0]  req_dest_idx = '0;
    logic [1:0]  req_class = '0;
    logic [3:0]  req_hash = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [11:0] rsp_mask;
    logic        rsp_cpu_copy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [11:0] m_tbl [92];
    logic [3:0]  m_cpu;
    logic [6:0]  m_fuc, m_fmc, m_fbc;

    always #10 clk = ~clk;

    pmr_resolver dut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_src_port(req_src_port),
        .req_hit(req_hit), .req_dest_idx(req_dest_idx), .req_class(req_class),
        .req_hash(req_hash), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_mask(rsp_mask), .rsp_cpu_copy(rsp_cpu_copy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 92; i++) m_tbl[i] = '0;
        m_cpu = '0; m_fuc = '0; m_fmc = '0; m_fbc = '0;
    endtask

    task automatic model_write(input logic [6:0] a, input logic [11:0] d);
        if (a < 7'd92) m_tbl[a] = d;
        else if (a == 7'd96) m_cpu = d[3:0];
        else if (a == 7'd97) m_fuc = d[6:0];
        else if (a == 7'd98) m_fmc = d[6:0];
        else if (a == 7'd99) m_fbc = d[6:0];
    endtask

    function automatic logic [12:0] expect_of(input logic [3:0] s, input logic h,
            input logic [6:0] di, input logic [1:0] c, input logic [3:0] hs);
        logic [6:0]  idx;
        logic [11:0] dst, srcm, m;
        logic        cc;
        idx  = h ? di : (c == 2'd0 ? m_fuc : (c == 2'd1 ? m_fmc : m_fbc));
        dst  = (idx < 7'd92) ? m_tbl[idx] : 12'h0;
        srcm = (s < 4'd12) ? m_tbl[80 + int'(s)] : 12'h0;
        m    = dst & m_tbl[64 + int'(hs)] & srcm;
        if (s < 4'd12) m[s] = 1'b0;
        cc = h && (m_cpu < 4'd12) && dst[m_cpu];
        if (cc) m[m_cpu] = 1'b0;
        return {cc, m};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic lookup(input string tag, input logic [3:0] s, input logic h,
            input logic [6:0] di, input logic [1:0] c, input logic [3:0] hs,
            input bit do_wr, input logic [6:0] wa, input logic [11:0] wd);
        logic [12:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_src_port = s; req_hit = h;
        req_dest_idx = di; req_class = c; req_hash = hs;
        if (do_wr) begin
            cfg_wr_en = 1'b1; cfg_wr_addr = wa; cfg_wr_data = wd;
        end
        e = expect_of(s, h, di, c, hs);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr_en = 1'b0;
        if (do_wr) model_write(wa, wd);
        check({tag, " R2 no early valid"}, {31'd0, rsp_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " mask"}, {20'd0, rsp_mask}, {20'd0, e[11:0]});
        check({tag, " cpu_copy"}, {31'd0, rsp_cpu_copy}, {31'd0, e[12]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] ea, eb;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst = 1'b0;

        // R1: empty table gives nothing
        lookup("R1 empty hit", 4'd2, 1'b1, 7'd59, 2'd0, 4'd0, 0, '0, '0);
        lookup("R1 empty flood", 4'd2, 1'b0, 7'd0, 2'd2, 4'd3, 0, '0, '0);

        // set up: CPU port 11, groups, aggregation, source masks
        wr(7'd96, 12'd11);
        for (int i = 0; i < 12; i++) wr(7'(i), 12'(1 << i));
        wr(7'd59, 12'h800);
        wr(7'd60, 12'hFFF);
        wr(7'd61, 12'h0F0);
        wr(7'd62, 12'hFFF);
        wr(7'd97, 12'd60);
        wr(7'd98, 12'd61);
        wr(7'd99, 12'd62);
        for (int i = 0; i < 16; i++) wr(7'(64 + i), 12'hFFF);
        for (int i = 0; i < 12; i++) wr(7'(80 + i), (i == 11) ? 12'h7FF : 12'h7FF);

        lookup("R6 hit CPU group", 4'd2, 1'b1, 7'd59, 2'd0, 4'd1, 0, '0, '0);
        lookup("R3 hit unicast", 4'd2, 1'b1, 7'd5, 2'd0, 4'd1, 0, '0, '0);
        lookup("R7 flood uc", 4'd2, 1'b0, 7'd59, 2'd0, 4'd7, 0, '0, '0);
        lookup("R4 flood mc", 4'd5, 1'b0, 7'd0, 2'd1, 4'd7, 0, '0, '0);
        lookup("R4 flood bc class3", 4'd0, 1'b0, 7'd0, 2'd3, 4'd2, 0, '0, '0);
        lookup("R5 self dest", 4'd3, 1'b1, 7'd3, 2'd0, 4'd0, 0, '0, '0);
        lookup("R10 src out of range", 4'd13, 1'b1, 7'd60, 2'd0, 4'd0, 0, '0, '0);
        lookup("R10 dest out of range", 4'd1, 1'b1, 7'd100, 2'd0, 4'd0, 0, '0, '0);

        // R7: CPU allowed in source mask for port 4, flooded frame reaches CPU through mask only
        wr(7'd84, 12'hFFF);
        lookup("R7 flood with cpu permitted", 4'd4, 1'b0, 7'd0, 2'd2, 4'd0, 0, '0, '0);

        // R8: writes to unmapped addresses are ignored
        wr(7'd93, 12'hABC);
        wr(7'd100, 12'd5);
        wr(7'd127, 12'h3);
        lookup("R8 ignored write cfg kept", 4'd2, 1'b0, 7'd0, 2'd1, 4'd0, 0, '0, '0);
        lookup("R8 ignored write cpu kept", 4'd2, 1'b1, 7'd59, 2'd0, 4'd0, 0, '0, '0);

        // R9: same-edge write uses old contents
        lookup("R9 same edge write", 4'd0, 1'b1, 7'd3, 2'd0, 4'd0, 1, 7'd3, 12'hFFF);
        lookup("R9 after write", 4'd0, 1'b1, 7'd3, 2'd0, 4'd0, 0, '0, '0);

        // R10: CPU port out of range
        wr(7'd96, 12'd14);
        lookup("R10 cpu out of range", 4'd2, 1'b1, 7'd60, 2'd0, 4'd0, 0, '0, '0);
        wr(7'd96, 12'd11);

        // R2: stall with two requests in flight
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_src_port = 4'd1; req_hit = 1'b1; req_dest_idx = 7'd59;
        req_class = 2'd0; req_hash = 4'd0;
        ea = expect_of(4'd1, 1'b1, 7'd59, 2'd0, 4'd0);
        @(posedge clk);
        @(negedge clk);
        req_src_port = 4'd6; req_hit = 1'b0; req_class = 2'd1;
        eb = expect_of(4'd6, 1'b0, 7'd0, 2'd1, 4'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 stall valid", {31'd0, rsp_valid}, 32'd1);
        check("R2 stall first mask", {20'd0, rsp_mask}, {20'd0, ea[11:0]});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2 stall held mask", {20'd0, rsp_mask}, {20'd0, ea[11:0]});
            check("R2 stall held copy", {31'd0, rsp_cpu_copy}, {31'd0, ea[12]});
            check("R2 stall ready low", {31'd0, req_ready}, 32'd0);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 second valid", {31'd0, rsp_valid}, 32'd1);
        check("R2 second mask", {20'd0, rsp_mask}, {20'd0, eb[11:0]});
        check("R2 second copy", {31'd0, rsp_cpu_copy}, {31'd0, eb[12]});
        @(posedge clk);
        @(negedge clk);
        check("R2 drained", {31'd0, rsp_valid}, 32'd0);

        // random mix, checked against the model (R3 R4 R5 R6 R7)
        for (int n = 0; n < 400; n++) begin
            logic [6:0] wa;
            wa = 7'($urandom_range(0, 101));
            if ($urandom_range(0, 1) == 1)
                wr(wa, 12'($urandom));
            lookup("R5 random", 4'($urandom_range(0, 13)), 1'($urandom),
                   7'($urandom_range(0, 95)), 2'($urandom), 4'($urandom),
                   1'($urandom_range(0, 3) == 0), 7'($urandom_range(0, 91)), 12'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule